// File: doc/BRIEF.md
# Idle-Timed Open Page Closer

This block sits inside a DRAM controller and remembers, for every bank, whether a row is open and which row it is. Each request accepted from the scheduler is sorted into one of three classes: a page hit (the requested row is already open), a page miss (the bank has no open row) or a page conflict (a different row is open). A miss produces an activate command right away. A conflict produces a precharge first and the activate one cycle later.

Each bank also has an idle timer. A 3-bit select picks how long an open page may sit unused before the block closes it with a precharge. The choices are zero, 16, 32, 64 or 96 idle cycles, never, or an automatic default of 16. When a refresh falls due, every open page is closed at once, whatever its timer shows. Idle closes leave the block one bank per cycle, lowest bank index first. A bank that waits for its idle close refuses new requests until the close has gone out.

Top module: `dram_page_keeper`

## Requirements
- R1: A request is accepted in any cycle where `req_valid_i` and `req_ready_o` are both high. In the next cycle exactly one of `hit_o` (requested row is already open), `miss_o` (the bank holds no open row) or `conflict_o` (another row is open) pulses for one cycle. None of them pulses in a cycle that follows no accepted request.
- R2: An accepted miss drives `act_valid_o` high in the next cycle, with `act_bank_o`/`act_row_o` set to the requested bank and row. That row is then open, so a repeat of the same request is a hit.
- R3: An accepted conflict drives `pre_valid_o` with `pre_bank_o` set to that bank in the next cycle. The activate for the new row follows one cycle later. In the cycle after the conflict is accepted, `req_ready_o` is low.
- R4: `limit_sel_i` encodes the idle limit L as follows: 0 gives 0, 1 gives 16, 2 gives 32, 3 gives 64, 4 gives 96, 5 gives never, and 6 or 7 give the automatic value of 16.
- R5: Suppose a bank is opened or touched by a request accepted in cycle a, it sees no further request, and no other close is queued. Its idle-close precharge then appears on `pre_valid_o`/`pre_bank_o` in cycle a + max(L,1) + 2. After that the bank is closed, so its next request is a miss.
- R6: An accepted request to an open bank restarts that bank's idle count. The close then comes max(L,1) + 2 cycles after that request.
- R7: With the never code, an open page stays open for any number of idle cycles and issues no idle-close precharge.
- R8: If several banks become due for an idle close in the same cycle, their precharges go out in consecutive cycles, one bank per cycle, lowest index first. While a bank's close is queued, `req_ready_o` is low for requests to that bank, and such a request is not classified.
- R9: If a conflict precharge and a queued idle close fall in the same cycle, the conflict precharge goes out first. The idle close goes out in the following cycle.
- R10: While `refresh_due_i` is high, `req_ready_o` is low. In the next cycle `pre_all_o` pulses and `pre_valid_o` and `act_valid_o` stay low. All pages are closed, queued idle closes are dropped and any deferred activate is cancelled, so no idle precharge follows later.
- R11: After reset no page is open, every output is low and `req_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present |
| req_bank_i | input | BANK_W | Bank of the request |
| req_row_i | input | ROW_W | Row of the request |
| req_ready_o | output | 1 | Request can be accepted this cycle |
| limit_sel_i | input | 3 | Idle limit code |
| refresh_due_i | input | 1 | Refresh pulse, closes all pages |
| hit_o | output | 1 | Previous request was a page hit |
| miss_o | output | 1 | Previous request was a page miss |
| conflict_o | output | 1 | Previous request was a page conflict |
| pre_valid_o | output | 1 | Single-bank precharge request |
| pre_bank_o | output | BANK_W | Bank to precharge |
| pre_all_o | output | 1 | Precharge-all request on refresh |
| act_valid_o | output | 1 | Activate request |
| act_bank_o | output | BANK_W | Bank to activate |
| act_row_o | output | ROW_W | Row to activate |

## Verification
A wrong open-row or open-flag entry shows up at the next request to that bank, in the following cycle, as the wrong one of the three class pulses and a missing or extra activate. A timer that counts one step wrong moves the idle precharge by exactly that many cycles, so the close cycle is measured for every limit code. Arbitration errors change the bank order of back-to-back precharges. A refresh that leaves state behind shows up as a hit, or a late idle precharge, on a page that should be closed.

// File: rtl/dpk_pkg.sv
package dpk_pkg;
    typedef enum logic [2:0] {
        LIM_0T    = 3'd0,
        LIM_16T   = 3'd1,
        LIM_32T   = 3'd2,
        LIM_64T   = 3'd3,
        LIM_96T   = 3'd4,
        LIM_NEVER = 3'd5,
        LIM_AUTO  = 3'd6
    } lim_code_e;

    localparam int IDLE_16 = 16;
    localparam int IDLE_32 = 32;
    localparam int IDLE_64 = 64;
    localparam int IDLE_96 = 96;
endpackage

// File: rtl/dpk_limit_decode.sv
module dpk_limit_decode #(
    parameter int CNT_W      = 7,
    parameter int AUTO_LIMIT = 16
) (
    input  logic [2:0]       code_i,
    output logic [CNT_W-1:0] limit_o,
    output logic             never_o
);
    import dpk_pkg::*;

    always_comb begin
        never_o = 1'b0;
        case (code_i)
            LIM_0T:    limit_o = '0;
            LIM_16T:   limit_o = CNT_W'(IDLE_16);
            LIM_32T:   limit_o = CNT_W'(IDLE_32);
            LIM_64T:   limit_o = CNT_W'(IDLE_64);
            LIM_96T:   limit_o = CNT_W'(IDLE_96);
            LIM_NEVER: begin
                limit_o = '0;
                never_o = 1'b1;
            end
            default:   limit_o = CNT_W'(AUTO_LIMIT);
        endcase
    end
endmodule

// File: rtl/dpk_bank_timer.sv
module dpk_bank_timer #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch_i,
    input  logic             kill_i,
    input  logic             open_i,
    input  logic             pend_i,
    input  logic             never_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             due_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W:0]   next_idle;

    always_comb begin
        next_idle = {1'b0, cnt_q} + 1'b1;
        cnt_d     = cnt_q;
        if (kill_i || touch_i) begin
            cnt_d = '0;
        end else if (open_i && (cnt_q != CNT_MAX)) begin
            cnt_d = cnt_q + 1'b1;
        end
        // due at the end of the idle cycle that brings the count to the limit
        due_o = open_i && !touch_i && !pend_i && !never_i
                && (next_idle >= {1'b0, limit_i});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/dpk_close_arb.sv
module dpk_close_arb #(
    parameter int NUM_BANKS = 4,
    parameter int BANK_W    = 2
) (
    input  logic [NUM_BANKS-1:0] pend_i,
    output logic                 valid_o,
    output logic [BANK_W-1:0]    idx_o
);
    always_comb begin
        valid_o = 1'b0;
        idx_o   = '0;
        // scan downward so the lowest pending index is the last assignment
        for (int b = NUM_BANKS - 1; b >= 0; b--) begin
            if (pend_i[b]) begin
                valid_o = 1'b1;
                idx_o   = BANK_W'(b);
            end
        end
    end
endmodule

// File: rtl/dram_page_keeper.sv
module dram_page_keeper #(
    parameter int NUM_BANKS  = 8,
    parameter int ROW_W      = 14,
    parameter int CNT_W      = 7,
    parameter int AUTO_LIMIT = 16,
    localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    input  logic [BANK_W-1:0] req_bank_i,
    input  logic [ROW_W-1:0]  req_row_i,
    output logic              req_ready_o,
    input  logic [2:0]        limit_sel_i,
    input  logic              refresh_due_i,
    output logic              hit_o,
    output logic              miss_o,
    output logic              conflict_o,
    output logic              pre_valid_o,
    output logic [BANK_W-1:0] pre_bank_o,
    output logic              pre_all_o,
    output logic              act_valid_o,
    output logic [BANK_W-1:0] act_bank_o,
    output logic [ROW_W-1:0]  act_row_o
);
    typedef struct packed {
        logic [NUM_BANKS-1:0]            open;
        logic [NUM_BANKS-1:0][ROW_W-1:0] row;
        logic [NUM_BANKS-1:0]            pend;
        logic                            act_pend;
        logic [BANK_W-1:0]               act_pend_bank;
        logic [ROW_W-1:0]                act_pend_row;
        logic                            hit;
        logic                            miss;
        logic                            conf;
        logic                            pre_valid;
        logic [BANK_W-1:0]               pre_bank;
        logic                            pre_all;
        logic                            act_valid;
        logic [BANK_W-1:0]               act_bank;
        logic [ROW_W-1:0]                act_row;
    } state_t;

    state_t st_d, st_q;

    logic [CNT_W-1:0]     limit;
    logic                 never;
    logic [NUM_BANKS-1:0] due;
    logic [NUM_BANKS-1:0] touch;
    logic [NUM_BANKS-1:0] kill;
    logic                 arb_valid;
    logic [BANK_W-1:0]    arb_idx;
    logic                 acc;
    logic                 req_open;
    logic                 row_match;
    logic                 cls_hit, cls_miss, cls_conf;
    logic                 close_go;

    dpk_limit_decode #(.CNT_W(CNT_W), .AUTO_LIMIT(AUTO_LIMIT)) u_dec (
        .code_i  (limit_sel_i),
        .limit_o (limit),
        .never_o (never)
    );

    dpk_close_arb #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_arb (
        .pend_i  (st_q.pend),
        .valid_o (arb_valid),
        .idx_o   (arb_idx)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        dpk_bank_timer #(.CNT_W(CNT_W)) u_tmr (
            .clk     (clk),
            .rst_n   (rst_n),
            .touch_i (touch[b]),
            .kill_i  (kill[b]),
            .open_i  (st_q.open[b]),
            .pend_i  (st_q.pend[b]),
            .never_i (never),
            .limit_i (limit),
            .due_o   (due[b])
        );
    end

    // request acceptance, classification and per-bank strobes
    always_comb begin
        req_ready_o = !refresh_due_i && !st_q.act_pend && !st_q.pend[req_bank_i];
        acc         = req_valid_i && req_ready_o;
        req_open    = st_q.open[req_bank_i];
        row_match   = (st_q.row[req_bank_i] == req_row_i);
        cls_hit     = acc && req_open && row_match;
        cls_miss    = acc && !req_open;
        cls_conf    = acc && req_open && !row_match;
        close_go    = arb_valid && !cls_conf && !refresh_due_i;
        for (int b = 0; b < NUM_BANKS; b++) begin
            touch[b] = acc && (req_bank_i == BANK_W'(b));
            kill[b]  = refresh_due_i || (close_go && (arb_idx == BANK_W'(b)));
        end
    end

    // next state
    always_comb begin
        st_d           = st_q;
        st_d.hit       = cls_hit;
        st_d.miss      = cls_miss;
        st_d.conf      = cls_conf;
        st_d.pre_valid = 1'b0;
        st_d.pre_bank  = '0;
        st_d.pre_all   = 1'b0;
        st_d.act_valid = 1'b0;
        st_d.act_bank  = '0;
        st_d.act_row   = '0;

        if (st_q.act_pend) begin
            st_d.act_valid = 1'b1;
            st_d.act_bank  = st_q.act_pend_bank;
            st_d.act_row   = st_q.act_pend_row;
            st_d.act_pend  = 1'b0;
        end

        if (cls_miss) begin
            st_d.open[req_bank_i] = 1'b1;
            st_d.row[req_bank_i]  = req_row_i;
            st_d.act_valid        = 1'b1;
            st_d.act_bank         = req_bank_i;
            st_d.act_row          = req_row_i;
        end

        if (cls_conf) begin
            st_d.row[req_bank_i] = req_row_i;
            st_d.pre_valid       = 1'b1;
            st_d.pre_bank        = req_bank_i;
            st_d.act_pend        = 1'b1;
            st_d.act_pend_bank   = req_bank_i;
            st_d.act_pend_row    = req_row_i;
        end

        if (close_go) begin
            st_d.open[arb_idx] = 1'b0;
            st_d.pend[arb_idx] = 1'b0;
            st_d.pre_valid     = 1'b1;
            st_d.pre_bank      = arb_idx;
        end

        for (int b = 0; b < NUM_BANKS; b++) begin
            if (due[b]) st_d.pend[b] = 1'b1;
        end

        if (refresh_due_i) begin
            st_d.open      = '0;
            st_d.pend      = '0;
            st_d.act_pend  = 1'b0;
            st_d.act_valid = 1'b0;
            st_d.act_bank  = '0;
            st_d.act_row   = '0;
            st_d.pre_valid = 1'b0;
            st_d.pre_bank  = '0;
            st_d.pre_all   = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hit_o       = st_q.hit;
    assign miss_o      = st_q.miss;
    assign conflict_o  = st_q.conf;
    assign pre_valid_o = st_q.pre_valid;
    assign pre_bank_o  = st_q.pre_bank;
    assign pre_all_o   = st_q.pre_all;
    assign act_valid_o = st_q.act_valid;
    assign act_bank_o  = st_q.act_bank;
    assign act_row_o   = st_q.act_row;
endmodule

// File: rtl/dpk_checker.sv
module dpk_checker (
    input logic clk,
    input logic rst_n,
    input logic req_valid_i,
    input logic req_ready_o,
    input logic refresh_due_i,
    input logic hit_o,
    input logic miss_o,
    input logic conflict_o,
    input logic pre_valid_o,
    input logic pre_all_o,
    input logic act_valid_o
);
    // R1: one class per accepted request
    assert_one_class_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_ready_o) |=> ($countones({hit_o, miss_o, conflict_o}) == 1));

    // R1: no class without an accepted request
    assert_no_stray_class_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid_i && req_ready_o) |=> !(hit_o || miss_o || conflict_o));

    // R2: a miss carries its activate
    assert_miss_activates_R2: assert property (@(posedge clk) disable iff (!rst_n)
        miss_o |-> act_valid_o);

    // R3: a conflict carries its precharge, and its activate follows
    assert_conflict_precharges_R3: assert property (@(posedge clk) disable iff (!rst_n)
        conflict_o |-> (pre_valid_o && !act_valid_o));

    assert_conflict_then_act_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (conflict_o && !refresh_due_i) |=> act_valid_o);

    // R10: refresh yields precharge-all and nothing else
    assert_refresh_closes_R10: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_due_i |=> (pre_all_o && !pre_valid_o && !act_valid_o));

    // R1: a hit never activates
    assert_hit_no_act_R1: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> !act_valid_o);
endmodule

bind dram_page_keeper dpk_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid_i   (req_valid_i),
    .req_ready_o   (req_ready_o),
    .refresh_due_i (refresh_due_i),
    .hit_o         (hit_o),
    .miss_o        (miss_o),
    .conflict_o    (conflict_o),
    .pre_valid_o   (pre_valid_o),
    .pre_all_o     (pre_all_o),
    .act_valid_o   (act_valid_o)
);

// File: tb/dram_page_keeper_tb.sv
module dram_page_keeper_tb;
    localparam int NB = 4;
    localparam int RW = 4;
    localparam int WD_LIMIT = 60000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid_i = 1'b0;
    logic [1:0]    req_bank_i = '0;
    logic [RW-1:0] req_row_i = '0;
    logic          req_ready_o;
    logic [2:0]    limit_sel_i = '0;
    logic          refresh_due_i = 1'b0;
    logic          hit_o, miss_o, conflict_o;
    logic          pre_valid_o, pre_all_o, act_valid_o;
    logic [1:0]    pre_bank_o, act_bank_o;
    logic [RW-1:0] act_row_o;

    int checks = 0;
    int fails = 0;
    int cycles = 0;

    logic s_ready, o_hit, o_miss, o_conf, o_pre, o_pall, o_act;
    int   o_pbank, o_abank, o_arow;

    dram_page_keeper #(.NUM_BANKS(NB), .ROW_W(RW), .CNT_W(7), .AUTO_LIMIT(16)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid_i), .req_bank_i(req_bank_i),
        .req_row_i(req_row_i), .req_ready_o(req_ready_o), .limit_sel_i(limit_sel_i),
        .refresh_due_i(refresh_due_i), .hit_o(hit_o), .miss_o(miss_o),
        .conflict_o(conflict_o), .pre_valid_o(pre_valid_o), .pre_bank_o(pre_bank_o),
        .pre_all_o(pre_all_o), .act_valid_o(act_valid_o), .act_bank_o(act_bank_o),
        .act_row_o(act_row_o)
    );

    always #4 clk = ~clk;

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == WD_LIMIT) begin
            checks = checks + 1;
            fails  = fails + 1;
            $display("FAIL watchdog: act=%0d exp=<%0d cycles", cycles, WD_LIMIT);
            report();
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            fails = fails + 1;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic capture();
        o_hit = hit_o; o_miss = miss_o; o_conf = conflict_o;
        o_pre = pre_valid_o; o_pall = pre_all_o; o_act = act_valid_o;
        o_pbank = int'(pre_bank_o); o_abank = int'(act_bank_o); o_arow = int'(act_row_o);
    endtask

    // one cycle: drive at the falling edge, sample after the next falling edge
    task automatic cyc(input logic v, input int b, input int r, input logic rf);
        req_valid_i   = v;
        req_bank_i    = b[1:0];
        req_row_i     = r[RW-1:0];
        refresh_due_i = rf;
        #1;
        s_ready = req_ready_o;
        @(negedge clk);
        capture();
        req_valid_i   = 1'b0;
        refresh_due_i = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        req_valid_i = 1'b0;
        refresh_due_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    function automatic int lim_of(input int code);
        case (code)
            0: return 0;
            1: return 16;
            2: return 32;
            3: return 64;
            4: return 96;
            5: return -1;
            default: return 16;
        endcase
    endfunction

    initial begin
        // R11: reset state
        do_reset();
        #1;
        chk("R11 ready", int'(req_ready_o), 1);
        chk("R11 outputs", int'({hit_o, miss_o, conflict_o, pre_valid_o, pre_all_o, act_valid_o}), 0);
        @(negedge clk);

        // R1/R2/R3 basic classes, never limit so no idle close interferes
        limit_sel_i = 3'd5;
        cyc(1, 0, 5, 0);
        chk("R2 miss", int'(o_miss), 1);
        chk("R2 act", int'(o_act), 1);
        chk("R2 act row", o_arow, 5);
        cyc(1, 0, 5, 0);
        chk("R1 hit", int'(o_hit), 1);
        chk("R1 hit no act/pre", int'({o_act, o_pre}), 0);
        cyc(1, 0, 6, 0);
        chk("R3 conflict", int'(o_conf), 1);
        chk("R3 pre bank0", int'(o_pre) * 10 + o_pbank, 10);
        chk("R3 no act yet", int'(o_act), 0);
        cyc(1, 2, 1, 0);
        chk("R3 ready low after conflict", int'(s_ready), 0);
        chk("R3 deferred act", int'(o_act) * 100 + o_abank * 10 + o_arow, 106);
        chk("R1 held request unclassified", int'({o_hit, o_miss, o_conf}), 0);
        cyc(1, 0, 6, 0);
        chk("R1 hit new row", int'(o_hit), 1);

        // R4/R5/R7 sweep over every limit code
        for (int code = 0; code < 8; code++) begin
            int found;
            int expk;
            int lim;
            do_reset();
            limit_sel_i = code[2:0];
            lim = lim_of(code);
            cyc(1, 1, 3, 0);
            chk($sformatf("R2 miss code%0d", code), int'(o_miss), 1);
            found = -1;
            for (int k = 1; k <= 130; k++) begin
                cyc(0, 0, 0, 0);
                if (o_pre && o_pbank == 1 && found < 0) found = k;
            end
            expk = (lim < 0) ? -1 : (((lim < 1) ? 1 : lim) + 1);
            chk($sformatf("R5 R4 close time code%0d", code), found, expk);
            cyc(1, 1, 3, 0);
            if (lim < 0) chk("R7 page kept open", int'(o_hit), 1);
            else         chk($sformatf("R5 closed page misses code%0d", code), int'(o_miss), 1);
        end

        // R6: access restarts the idle count
        begin
            int found;
            do_reset();
            limit_sel_i = 3'd1;
            cyc(1, 1, 3, 0);
            found = -1;
            for (int k = 1; k <= 10; k++) begin
                cyc(0, 0, 0, 0);
                if (o_pre) found = k;
            end
            chk("R6 no early close", found, -1);
            cyc(1, 1, 3, 0);
            chk("R6 hit", int'(o_hit), 1);
            found = -1;
            for (int k = 1; k <= 40; k++) begin
                cyc(0, 0, 0, 0);
                if (o_pre && found < 0) found = k;
            end
            chk("R6 close after restart", found, 17);
        end

        // R8: lowest bank first, queued bank held off
        do_reset();
        limit_sel_i = 3'd5;
        cyc(1, 3, 1, 0);
        cyc(1, 1, 1, 0);
        cyc(1, 2, 1, 0);
        limit_sel_i = 3'd0;
        cyc(0, 0, 0, 0);
        chk("R8 nothing yet", int'(o_pre), 0);
        cyc(1, 3, 9, 0);
        chk("R8 queued bank held off", int'(s_ready), 0);
        chk("R8 first close bank1", int'(o_pre) * 10 + o_pbank, 11);
        chk("R8 held request unclassified", int'({o_hit, o_miss, o_conf}), 0);
        cyc(0, 0, 0, 0);
        chk("R8 second close bank2", int'(o_pre) * 10 + o_pbank, 12);
        cyc(0, 0, 0, 0);
        chk("R8 third close bank3", int'(o_pre) * 10 + o_pbank, 13);
        cyc(1, 3, 9, 0);
        chk("R8 closed bank3 misses", int'(o_miss), 1);

        // R9: conflict precharge before queued idle close
        do_reset();
        limit_sel_i = 3'd5;
        cyc(1, 2, 1, 0);
        cyc(1, 1, 1, 0);
        limit_sel_i = 3'd0;
        cyc(1, 1, 1, 0);
        chk("R9 setup hit", int'(o_hit), 1);
        cyc(1, 1, 2, 0);
        chk("R9 conflict wins precharge", int'(o_conf) * 100 + int'(o_pre) * 10 + o_pbank, 111);
        cyc(0, 0, 0, 0);
        chk("R9 idle close next cycle", int'(o_pre) * 10 + o_pbank, 12);
        chk("R3 act after conflict", int'(o_act) * 100 + o_abank * 10 + o_arow, 112);
        cyc(0, 0, 0, 0);
        chk("R9 bank1 closes next", int'(o_pre) * 10 + o_pbank, 11);

        // R10: refresh closes pages regardless of the limit
        do_reset();
        limit_sel_i = 3'd5;
        cyc(1, 0, 2, 0);
        repeat (3) cyc(0, 0, 0, 0);
        cyc(1, 1, 7, 1);
        chk("R10 ready low", int'(s_ready), 0);
        chk("R10 pre_all only", int'({o_pall, o_pre, o_act}), 4);
        chk("R10 request unclassified", int'({o_hit, o_miss, o_conf}), 0);
        cyc(1, 0, 2, 0);
        chk("R10 page closed", int'(o_miss), 1);

        begin
            int seen;
            do_reset();
            limit_sel_i = 3'd1;
            cyc(1, 1, 3, 0);
            repeat (5) cyc(0, 0, 0, 0);
            cyc(0, 0, 0, 1);
            chk("R10 pre_all pulse", int'(o_pall), 1);
            seen = 0;
            for (int k = 0; k < 30; k++) begin
                cyc(0, 0, 0, 0);
                if (o_pre || o_pall) seen++;
            end
            chk("R10 no later idle close", seen, 0);
        end

        report();
        $finish;
    end
endmodule